// File: doc/BRIEF.md
# SAR Conversion Timing Controller

This block runs one successive-approximation conversion at a time. The queue logic places a channel code on the input multiplexer and then pulses a start request. With that pulse it supplies a 2-bit sample-length code and a flag that skips the amplifier stage. The controller first holds the amplifier for a short settling interval. When the flag is set, that interval is skipped. It then holds the sample phase for the selected number of cycles. After that it resolves ten result bits, one per clock, from the most significant bit down. In each bit cycle it drives a trial code to an external DAC and reads back one comparator decision.

When the last bit is resolved, the controller loads the ten-bit result into a holding register. In the same cycle it raises a one-cycle end-of-conversion strobe, which tells the queue logic to store the value. A power-down input stops all conversion activity: it blocks new starts and abandons any conversion in progress. A start request that arrives during a conversion is dropped, and a sticky error flag records it.

Top module: `sarc_ctrl`

## Requirements
- R1: A start pulse sampled while idle and not powered down begins a conversion. From the next cycle busy_o is high and chan_o holds the channel code given with the pulse.
- R2: When the bypass flag is 0, the conversion opens with exactly 2 cycles in which amp_en_o is high. When the flag is 1, amp_en_o stays low for the whole conversion.
- R3: The sample phase, marked by sample_o, lasts 2, 4, 8 or 16 cycles for sample code 0, 1, 2 or 3. It follows the settling interval, or the start when settling is skipped.
- R4: The approximation phase lasts 10 cycles and tests bit 9 first, then bit 8, down to bit 0. In each of these cycles trial_o is the bits kept so far plus the bit under test set to 1. That bit is kept when cmp_i is 1, meaning the input is at or above the trial level. Outside this phase trial_o is 0.
- R5: result_o changes only in the cycle eoc_o is high. With an ideal comparator it then equals the input code.
- R6: eoc_o is high for exactly one cycle, the cycle after the last bit decision. busy_o is low in that cycle.
- R7: A start pulse sampled while busy is ignored: the running conversion, its channel and its result are unaffected. It also sets err_o, which stays high until reset.
- R8: A start pulse sampled while halt_i is high and the block is idle is ignored and does not set err_o.
- R9: halt_i sampled high during a conversion returns the block to idle on the next cycle. No eoc_o pulse follows, and result_o keeps its previous value.
- R10: After reset, busy_o, amp_en_o, sample_o, eoc_o and err_o are 0, and result_o, trial_o and chan_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Power-down: blocks starts and aborts a running conversion |
| start_i | input | 1 | Start-conversion pulse, channel already applied |
| chan_i | input | CH_W | Channel code accompanying the start |
| stime_i | input | 2 | Sample-length code (2, 4, 8 or 16 cycles) |
| bypass_i | input | 1 | 1 skips the amplifier settling interval |
| cmp_i | input | 1 | Comparator decision, 1 when input is at or above trial_o |
| chan_o | output | CH_W | Channel of the current or last conversion |
| amp_en_o | output | 1 | Amplifier settling interval active |
| sample_o | output | 1 | Sample phase active |
| trial_o | output | RES_W | Trial code to the DAC during approximation |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | RES_W | Last completed result |
| eoc_o | output | 1 | One-cycle end-of-conversion strobe |
| err_o | output | 1 | Sticky flag: start seen while busy |

## Verification
The hardest cases to reach from the ports are interruptions that land in the middle of a phase. One is a second start arriving partway through a long sample phase. The other is power-down arriving partway through the bit decisions. The stimulus counts cycles from the accepted start and injects the intruding pulse on a chosen cycle. It then checks that the first conversion keeps its channel, timing and result, or that it vanishes without a strobe. The arithmetic itself is covered by a comparator model that follows trial_o against a fixed input level. That model is swept over all 1024 codes with the shortest timing, and over every timing setting for a few edge codes.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_SAMPLE = 2'd2,
        PH_CONV   = 2'd3
    } sarc_phase_e;
endpackage

// File: rtl/sarc_phase_timer.sv
// Down counter that measures the length of the settling and sample phases.
module sarc_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i)
            st_d.cnt = len_i;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last_o = (st_q.cnt == CNT_W'(1));

    // R3: once a phase has reached its last cycle, the counter is idle unless reloaded
    assert_timer_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !load_i) |=> (st_q.cnt == '0));
endmodule

// File: rtl/sarc_approx_reg.sv
// Bit-serial approximation register: one comparator decision per cycle, MSB first.
module sarc_approx_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] final_o,
    output logic             last_o
);
    typedef struct packed {
        logic [RES_W-1:0] acc;
        logic [RES_W-1:0] probe;
    } sar_t;

    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    sar_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.acc   = '0;
            st_d.probe = TOP_BIT;
        end else if (step_i) begin
            if (cmp_i) st_d.acc = st_q.acc | st_q.probe;
            st_d.probe = st_q.probe >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trial_o = st_q.acc | st_q.probe;
    assign final_o = cmp_i ? trial_o : st_q.acc;
    assign last_o  = step_i && st_q.probe[0];

    // R4: exactly one bit is under test in each stepping cycle
    assert_single_probe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> $onehot(st_q.probe));
    // R4: bits already resolved never change while stepping
    assert_kept_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !st_q.probe[0]) |=> ((st_q.acc & ~($past(st_q.probe) | st_q.probe)) == ($past(st_q.acc) & ~$past(st_q.probe))));
endmodule

// File: rtl/sarc_ctrl.sv
// Conversion sequencer: settling, sample and approximation phases, result handoff.
module sarc_ctrl #(
    parameter int RES_W       = 10,
    parameter int CH_W        = 5,
    parameter int SETTLE_CYC  = 2,
    parameter int SAMPLE_BASE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [1:0]       stime_i,
    input  logic             bypass_i,
    input  logic             cmp_i,
    output logic [CH_W-1:0]  chan_o,
    output logic             amp_en_o,
    output logic             sample_o,
    output logic [RES_W-1:0] trial_o,
    output logic             busy_o,
    output logic [RES_W-1:0] result_o,
    output logic             eoc_o,
    output logic             err_o
);
    import sarc_pkg::*;

    localparam int SAMPLE_MAX = SAMPLE_BASE << 3;
    localparam int CNT_W      = $clog2(SAMPLE_MAX + 1);

    typedef struct packed {
        sarc_phase_e      phase;
        logic [CH_W-1:0]  chan;
        logic [1:0]       stime;
        logic [RES_W-1:0] res;
        logic             eoc;
        logic             err;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic             t_load, t_last;
    logic [CNT_W-1:0] t_len;
    logic             s_clear, s_step, s_last;
    logic [RES_W-1:0] s_trial, s_final;

    function automatic logic [CNT_W-1:0] sample_len(input logic [1:0] code);
        return CNT_W'(SAMPLE_BASE) << code;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.eoc = 1'b0;
        t_load   = 1'b0;
        t_len    = '0;
        s_clear  = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i && !halt_i) begin
                    st_d.chan  = chan_i;
                    st_d.stime = stime_i;
                    t_load     = 1'b1;
                    if (bypass_i) begin
                        st_d.phase = PH_SAMPLE;
                        t_len      = sample_len(stime_i);
                    end else begin
                        st_d.phase = PH_SETTLE;
                        t_len      = CNT_W'(SETTLE_CYC);
                    end
                end
            end
            PH_SETTLE: begin
                if (t_last) begin
                    st_d.phase = PH_SAMPLE;
                    t_load     = 1'b1;
                    t_len      = sample_len(st_q.stime);
                end
            end
            PH_SAMPLE: begin
                if (t_last) begin
                    st_d.phase = PH_CONV;
                    s_clear    = 1'b1;
                end
            end
            PH_CONV: begin
                if (s_last) begin
                    st_d.phase = PH_IDLE;
                    st_d.res   = s_final;
                    st_d.eoc   = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
        if (st_q.phase != PH_IDLE) begin
            if (start_i) st_d.err = 1'b1;
            if (halt_i) begin
                st_d.phase = PH_IDLE;
                st_d.res   = st_q.res;
                st_d.eoc   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_step = (st_q.phase == PH_CONV);

    sarc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .len_i  (t_len),
        .last_o (t_last)
    );

    sarc_approx_reg #(.RES_W(RES_W)) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (s_clear),
        .step_i  (s_step),
        .cmp_i   (cmp_i),
        .trial_o (s_trial),
        .final_o (s_final),
        .last_o  (s_last)
    );

    assign chan_o   = st_q.chan;
    assign amp_en_o = (st_q.phase == PH_SETTLE);
    assign sample_o = (st_q.phase == PH_SAMPLE);
    assign busy_o   = (st_q.phase != PH_IDLE);
    assign trial_o  = s_step ? s_trial : '0;
    assign result_o = st_q.res;
    assign eoc_o    = st_q.eoc;
    assign err_o    = st_q.err;

    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !halt_i) |=> (busy_o && chan_o == $past(chan_i)));
    assert_phase_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({amp_en_o, sample_o, s_step}));
    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_o |-> $stable(result_o));
    assert_eoc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |-> (!busy_o && !$past(eoc_o)));
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    assert_busy_start_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (err_o && chan_o == $past(chan_o)));
    assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !busy_o) |=> (!busy_o && err_o == $past(err_o)));
    assert_halt_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && busy_o) |=> (!busy_o && !eoc_o));
endmodule

// File: tb/sarc_ctrl_tb.sv
module sarc_ctrl_tb;
    localparam int PERIOD = 10;
    localparam int RES_W  = 10;
    localparam int CH_W   = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             halt_i = 1'b0;
    logic             start_i = 1'b0;
    logic [CH_W-1:0]  chan_i = '0;
    logic [1:0]       stime_i = '0;
    logic             bypass_i = 1'b0;
    logic             cmp_i;
    logic [CH_W-1:0]  chan_o;
    logic             amp_en_o, sample_o, busy_o, eoc_o, err_o;
    logic [RES_W-1:0] trial_o, result_o;

    int vin = 0;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    // ideal comparator against a fixed input level
    always_comb cmp_i = (vin >= int'(trial_o));

    sarc_ctrl #(.RES_W(RES_W), .CH_W(CH_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .start_i(start_i),
        .chan_i(chan_i), .stime_i(stime_i), .bypass_i(bypass_i), .cmp_i(cmp_i),
        .chan_o(chan_o), .amp_en_o(amp_en_o), .sample_o(sample_o), .trial_o(trial_o),
        .busy_o(busy_o), .result_o(result_o), .eoc_o(eoc_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start_i = 1'b0;
        halt_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One conversion. intr > 0 injects a second start on that cycle after acceptance.
    // full=1 checks every step; full=0 only checks the result and strobe timing.
    task automatic run_conv(input int v, input int st, input bit byp, input int ch,
                            input int intr, input bit full);
        int s_len = byp ? 0 : 2;
        int n_len = 2 << st;
        int c0 = s_len + n_len + 1;
        int eoc_at = 0;
        int amp_cnt = 0;
        int smp_cnt = 0;
        bit trial_ok = 1;
        int bad_trial = 0;
        int bad_exp = 0;
        vin = v;
        @(negedge clk);
        start_i = 1'b1;
        chan_i = CH_W'(ch);
        stime_i = 2'(st);
        bypass_i = byp;
        @(negedge clk);
        start_i = 1'b0;
        if (full) begin
            chk(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
            chk(chan_o == CH_W'(ch), "R1 channel latched", chan_o, ch);
        end
        for (int k = 1; k < 60; k++) begin
            if (k > 1) @(negedge clk);
            if (amp_en_o) amp_cnt++;
            if (sample_o) smp_cnt++;
            if (k >= c0 && k < c0 + 10) begin
                int b = 9 - (k - c0);
                int exp_t = (v & ~((1 << (b + 1)) - 1)) | (1 << b);
                if (int'(trial_o) != exp_t && trial_ok) begin
                    trial_ok = 0;
                    bad_trial = int'(trial_o);
                    bad_exp = exp_t;
                end
            end
            if (intr != 0 && k == intr) begin
                start_i = 1'b1;
                chan_i = ~CH_W'(ch);
                vin = v;
            end else begin
                start_i = 1'b0;
            end
            if (eoc_o) begin
                eoc_at = k;
                break;
            end
        end
        start_i = 1'b0;
        chk(eoc_at == c0 + 10, "R6 eoc cycle", eoc_at, c0 + 10);
        chk(int'(result_o) == v, "R5 result value", int'(result_o), v);
        if (full) begin
            chk(amp_cnt == s_len, "R2 settle length", amp_cnt, s_len);
            chk(smp_cnt == n_len, "R3 sample length", smp_cnt, n_len);
            chk(trial_ok, "R4 trial sequence", bad_trial, bad_exp);
            chk(busy_o == 1'b0, "R6 busy low at eoc", busy_o, 0);
            chk(chan_o == CH_W'(ch), "R7 channel kept", chan_o, ch);
            @(negedge clk);
            chk(eoc_o == 1'b0, "R6 eoc one cycle", eoc_o, 0);
            chk(trial_o == '0, "R4 trial idle zero", trial_o, 0);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int codes[5] = '{0, 1023, 512, 341, 682};
        int prev;
        do_reset();
        // R10 reset state
        chk(busy_o == 0 && amp_en_o == 0 && sample_o == 0, "R10 phase outputs", busy_o, 0);
        chk(eoc_o == 0 && err_o == 0, "R10 strobes", err_o, 0);
        chk(result_o == '0 && trial_o == '0 && chan_o == '0, "R10 data outputs", int'(result_o), 0);

        // R8 start while powered down
        halt_i = 1'b1;
        start_i = 1'b1;
        chan_i = 5'd9;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b0, "R8 no start when halted", busy_o, 0);
        @(negedge clk);
        chk(err_o == 1'b0, "R8 no error when halted", err_o, 0);
        chk(chan_o == '0, "R8 channel untouched", chan_o, 0);
        halt_i = 1'b0;

        // R2 R3 R4 R5 R6 over every timing setting
        for (int st = 0; st < 4; st++)
            for (int byp = 0; byp < 2; byp++)
                for (int c = 0; c < 5; c++)
                    run_conv(codes[c], st, byp[0], (st * 8 + byp * 4 + c) % 32, 0, 1);
        chk(err_o == 1'b0, "R7 no error without collision", err_o, 0);

        // R5 sweep of all codes at the shortest timing
        for (int v = 0; v < 1024; v++) run_conv(v, 0, 1'b1, v % 32, 0, 0);

        // R9 abort by power-down mid-approximation
        prev = int'(result_o);
        vin = 300;
        @(negedge clk);
        start_i = 1'b1;
        chan_i = 5'd3;
        stime_i = 2'd0;
        bypass_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        halt_i = 1'b1;
        @(negedge clk);
        halt_i = 1'b0;
        chk(busy_o == 1'b0, "R9 idle after halt", busy_o, 0);
        begin
            bit saw = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (eoc_o) saw = 1;
            end
            chk(!saw, "R9 no eoc after abort", saw, 0);
        end
        chk(int'(result_o) == prev, "R9 result kept", int'(result_o), prev);

        // R7 second start during the sample phase
        run_conv(777, 2, 1'b0, 11, 6, 1);
        chk(err_o == 1'b1, "R7 error flag set", err_o, 1);
        run_conv(55, 1, 1'b1, 2, 0, 1);
        chk(err_o == 1'b1, "R7 error flag sticky", err_o, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule